// File: doc/BRIEF.md
# Calendar Real-Time Clock Register File

This block keeps wall-clock time and a calendar date in a small byte-addressed register file. It holds seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each pulse on a once-per-second strobe moves the whole set forward by one second, with carries that follow real month lengths and leap years. The host reads and writes the bytes over a simple synchronous bus: address, write data, write strobe, read strobe and a registered read-data port.

A control byte picks how the calendar bytes are encoded, either packed BCD or plain binary. The same byte also carries a fixed 24-hour flag, a bit that freezes the clock while software loads a new time, and a periodic-interrupt enable. When that enable is set, pulses on a periodic tick input reach the interrupt output. A status byte reports the time-base and rate codes together with an update-in-progress flag that flips on every read of that byte. A write to the control byte that sets a bit the block does not support is dropped, and a sticky error output is raised instead.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the status byte (address 10) holds 0x26 with its update flag (bit 7) clear. The control byte (address 11) holds 0x42, plus bit 2 when parameter RESET_BINARY is 1. The calendar reads Saturday 2000-01-01 00:00:00, which is 0x00 for seconds, minutes, hours and year, 0x01 for day of month and month, and 0x07 for day of week. The alarm bytes read 0 and cfg_err is low.
- R2: Time fields sit at seconds 0, minutes 2, hours 4, day of week 6, day of month 7, month 8 and year 9. Addresses 1, 3 and 5 are plain storage bytes. All ten bytes are writable and read back unchanged. Read data appears on bus_rdata on the clock edge that samples bus_re and holds until the next read.
- R3: With control bit 2 clear, each field is packed BCD (tens digit in bits 7:4, units digit in bits 3:0), and a pps_tick pulse advances the time by exactly one second.
- R4: With control bit 2 set, each field is plain binary, and a pps_tick pulse advances the time by exactly one second.
- R5: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0. Day of month wraps to 1 past the month's length (30 for April, June, September and November, 31 for the other months except February). Month wraps from 12 to 1.
- R6: February has 29 days when the two-digit year is divisible by 4 (00 counts as a leap year) and 28 days otherwise.
- R7: Day of week runs 1 to 7 (1 = Sunday), steps when the hours wrap, and goes from 7 back to 1. The year goes from 99 to 00.
- R8: While control bit 7 is set, pps_tick leaves every calendar byte unchanged.
- R9: Each read of the status byte flips its bit 7 and returns the value after the flip. A write to the status byte replaces bits 6:0 and leaves bit 7 unchanged.
- R10: A write to the control byte is accepted only when its bits 5, 4, 1 and 0 equal 0,0,1,0. Bits 7, 6, 3 and 2 are free. A rejected write leaves the control byte unchanged and sets cfg_err, which stays set until reset.
- R11: When control bit 6 is set, a prd_tick pulse gives a one-cycle irq pulse on the following clock edge. When the bit is clear, irq stays low.
- R12: Addresses 12, 13, 14 and 15 read as 0x00, and writes to them have no effect.
- R13: When a host write to a time field arrives in the same cycle as pps_tick, the written value is stored in that field, and the tick is not applied to that field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_tick | input | 1 | One-cycle pulse once per second |
| prd_tick | input | 1 | Periodic rate pulse to be gated onto irq |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Periodic interrupt pulse |
| cfg_err | output | 1 | Sticky flag for a rejected control write |

## Verification
The carry chain is tested with a table of start times. Each row is loaded, given one second and read back. The rows run from a lone units-digit carry up to a full cascade across the end of a day, a 30-day month, February in a leap year and in a common year, a leap day, and the end of the century window. The same boundaries are repeated in binary encoding. A BCD-only bug then shows up as a nibble carry at 9, and a binary-only bug as a wrap at the wrong count. Directed tests keep the inhibit bit, the flipping update flag, control-write rejection, interrupt gating and the write-versus-tick collision apart, because each one is driven on its own and checked through the bus or the irq pin.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int ADDR_W = 4;
    localparam int NUM_FIELDS = 7;
    localparam int NUM_SPARE = 3;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    typedef enum logic [ADDR_W-1:0] {
        AD_SEC    = 4'd0,
        AD_SPARE0 = 4'd1,
        AD_MIN    = 4'd2,
        AD_SPARE1 = 4'd3,
        AD_HOUR   = 4'd4,
        AD_SPARE2 = 4'd5,
        AD_WDAY   = 4'd6,
        AD_MDAY   = 4'd7,
        AD_MON    = 4'd8,
        AD_YEAR   = 4'd9,
        AD_STAT   = 4'd10,
        AD_CTRL   = 4'd11,
        AD_ZERO0  = 4'd12,
        AD_ZERO1  = 4'd13
    } reg_addr_e;

    localparam int CB_FREEZE = 7;
    localparam int CB_PIE    = 6;
    localparam int CB_BIN    = 2;

    localparam logic [7:0] CTRL_FREE_MASK = 8'hCC;
    localparam logic [7:0] CTRL_FIXED     = 8'h02;
    localparam logic [7:0] STAT_RESET     = 8'h26;
    localparam logic [7:0] CTRL_RESET     = 8'h42;
    localparam logic [55:0] TIME_RESET    = 56'h00010107000000;

    function automatic logic [ADDR_W-1:0] field_addr(input int idx);
        case (idx)
            0:       return AD_SEC;
            1:       return AD_MIN;
            2:       return AD_HOUR;
            3:       return AD_WDAY;
            4:       return AD_MDAY;
            5:       return AD_MON;
            default: return AD_YEAR;
        endcase
    endfunction

    function automatic logic [7:0] to_num(input logic [7:0] v, input logic bin);
        if (bin) return v;
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    function automatic logic [7:0] from_num(input logic [7:0] n, input logic bin);
        if (bin) return n;
        return {4'(n / 8'd10), 4'(n % 8'd10)};
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'd2:                      return (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_field_adv.sv
module rtc_field_adv (
    input  logic [7:0] cur,
    input  logic [7:0] lo,
    input  logic [7:0] hi,
    input  logic       step,
    output logic [7:0] nxt
);
    always_comb begin
        if (!step)
            nxt = cur;
        else if (cur >= hi)
            nxt = lo;
        else
            nxt = cur + 8'd1;
    end
endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    input  logic bin,
    output cal_t nxt
);
    localparam int NCH = 6;

    logic [7:0] bv [NCH];
    logic [7:0] lo [NCH];
    logic [7:0] hi [NCH];
    logic [7:0] nb [NCH];
    logic       carry [NCH];
    logic [7:0] wd_cur;
    logic [7:0] wd_nxt;

    assign bv[0] = to_num(cur.sec, bin);
    assign bv[1] = to_num(cur.min, bin);
    assign bv[2] = to_num(cur.hour, bin);
    assign bv[3] = to_num(cur.mday, bin);
    assign bv[4] = to_num(cur.mon, bin);
    assign bv[5] = to_num(cur.year, bin);

    assign lo[0] = 8'd0;  assign hi[0] = 8'd59;
    assign lo[1] = 8'd0;  assign hi[1] = 8'd59;
    assign lo[2] = 8'd0;  assign hi[2] = 8'd23;
    assign lo[3] = 8'd1;  assign hi[3] = month_len(bv[4], bv[5]);
    assign lo[4] = 8'd1;  assign hi[4] = 8'd12;
    assign lo[5] = 8'd0;  assign hi[5] = 8'd99;

    assign carry[0] = 1'b1;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chain
            rtc_field_adv u_adv (
                .cur  (bv[g]),
                .lo   (lo[g]),
                .hi   (hi[g]),
                .step (carry[g]),
                .nxt  (nb[g])
            );
            if (g < NCH - 1) begin : g_carry
                assign carry[g+1] = carry[g] && (bv[g] >= hi[g]);
            end
        end
    endgenerate

    assign wd_cur = to_num(cur.wday, bin);
    always_comb begin
        if (!carry[3])
            wd_nxt = wd_cur;
        else if (wd_cur >= 8'd7)
            wd_nxt = 8'd1;
        else
            wd_nxt = wd_cur + 8'd1;
    end

    assign nxt.sec  = from_num(nb[0], bin);
    assign nxt.min  = from_num(nb[1], bin);
    assign nxt.hour = from_num(nb[2], bin);
    assign nxt.mday = from_num(nb[3], bin);
    assign nxt.mon  = from_num(nb[4], bin);
    assign nxt.year = from_num(nb[5], bin);
    assign nxt.wday = from_num(wd_nxt, bin);
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
    import rtc_cal_pkg::*;
#(
    parameter bit RESET_BINARY = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stat,
    input  logic       wr_ctrl,
    input  logic       rd_stat,
    input  logic [7:0] wdata,
    input  logic       prd_tick,
    output logic [7:0] stat_q,
    output logic [7:0] ctrl_q,
    output logic       cfg_err,
    output logic       irq
);
    localparam logic [7:0] CTRL_INIT = CTRL_RESET | (RESET_BINARY ? 8'h04 : 8'h00);

    logic ctrl_ok;
    assign ctrl_ok = ((wdata & ~CTRL_FREE_MASK) == CTRL_FIXED);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= STAT_RESET;
            ctrl_q  <= CTRL_INIT;
            cfg_err <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (rd_stat)
                stat_q[7] <= ~stat_q[7];
            if (wr_stat)
                stat_q[6:0] <= wdata[6:0];
            if (wr_ctrl) begin
                if (ctrl_ok)
                    ctrl_q <= wdata;
                else
                    cfg_err <= 1'b1;
            end
            irq <= ctrl_q[CB_PIE] & prd_tick;
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter bit RESET_BINARY = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pps_tick,
    input  logic              prd_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              cfg_err
);
    logic [7:0]  tm_q [NUM_FIELDS];
    logic [7:0]  spare_q [NUM_SPARE];
    logic [7:0]  stat_q;
    logic [7:0]  ctrl_q;
    cal_t        cal_now;
    cal_t        cal_nxt;
    logic [55:0] nxt_vec;
    logic        advance;
    logic        spare_sel;
    logic [7:0]  rd_mux;

    assign cal_now = cal_t'({tm_q[6], tm_q[5], tm_q[4], tm_q[3],
                             tm_q[2], tm_q[1], tm_q[0]});
    assign nxt_vec = cal_nxt;
    assign advance = pps_tick && !ctrl_q[CB_FREEZE];

    rtc_cal_step u_step (
        .cur (cal_now),
        .bin (ctrl_q[CB_BIN]),
        .nxt (cal_nxt)
    );

    rtc_ctrl #(.RESET_BINARY(RESET_BINARY)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_stat  (bus_we && bus_addr == AD_STAT),
        .wr_ctrl  (bus_we && bus_addr == AD_CTRL),
        .rd_stat  (bus_re && bus_addr == AD_STAT),
        .wdata    (bus_wdata),
        .prd_tick (prd_tick),
        .stat_q   (stat_q),
        .ctrl_q   (ctrl_q),
        .cfg_err  (cfg_err),
        .irq      (irq)
    );

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
            localparam logic [ADDR_W-1:0] FA = field_addr(i);
            always_ff @(posedge clk) begin
                if (rst)
                    tm_q[i] <= TIME_RESET[i*8 +: 8];
                else if (bus_we && bus_addr == FA)
                    tm_q[i] <= bus_wdata;
                else if (advance)
                    tm_q[i] <= nxt_vec[i*8 +: 8];
            end
        end
    endgenerate

    assign spare_sel = (bus_addr == AD_SPARE0) || (bus_addr == AD_SPARE1) ||
                       (bus_addr == AD_SPARE2);

    generate
        for (genvar k = 0; k < NUM_SPARE; k++) begin : g_spare
            always_ff @(posedge clk) begin
                if (rst)
                    spare_q[k] <= 8'h00;
                else if (bus_we && spare_sel && bus_addr[2:1] == 2'(k))
                    spare_q[k] <= bus_wdata;
            end
        end
    endgenerate

    always_comb begin
        case (bus_addr)
            AD_SEC:    rd_mux = tm_q[0];
            AD_MIN:    rd_mux = tm_q[1];
            AD_HOUR:   rd_mux = tm_q[2];
            AD_WDAY:   rd_mux = tm_q[3];
            AD_MDAY:   rd_mux = tm_q[4];
            AD_MON:    rd_mux = tm_q[5];
            AD_YEAR:   rd_mux = tm_q[6];
            AD_SPARE0: rd_mux = spare_q[0];
            AD_SPARE1: rd_mux = spare_q[1];
            AD_SPARE2: rd_mux = spare_q[2];
            AD_STAT:   rd_mux = {~stat_q[7], stat_q[6:0]};
            AD_CTRL:   rd_mux = ctrl_q;
            default:   rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= 8'h00;
        else if (bus_re)
            bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pps_tick,
    input logic              prd_tick,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [7:0]        bus_rdata,
    input logic              irq,
    input logic              cfg_err,
    input logic [7:0]        ctrl_q,
    input cal_t              cal_now
);
    a_r11_irq_needs_tick: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(prd_tick) && $past(ctrl_q[CB_PIE])));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    a_r10_bad_ctrl_flags: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == AD_CTRL &&
         ((bus_wdata & ~CTRL_FREE_MASK) != CTRL_FIXED)) |=> (cfg_err && $stable(ctrl_q)));

    a_r8_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[CB_FREEZE] && pps_tick && !bus_we) |=> $stable(cal_now));

    a_r12_zero_regs: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr >= AD_ZERO0) |=> (bus_rdata == 8'h00));

    a_r9_flag_flips: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == AD_STAT && $past(bus_re && bus_addr == AD_STAT))
        |=> (bus_rdata[7] != $past(bus_rdata[7])));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pps_tick  (pps_tick),
    .prd_tick  (prd_tick),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .cfg_err   (cfg_err),
    .ctrl_q    (ctrl_q),
    .cal_now   (cal_now)
);

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
    typedef struct packed {
        logic        bin;
        logic [55:0] t0;
        logic [55:0] t1;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 56'h24031504102009, 56'h24031504102010},
        '{1'b0, 56'h24031504125959, 56'h24031504130000},
        '{1'b0, 56'h24043007235959, 56'h24050101000000},
        '{1'b0, 56'h23022803235959, 56'h23030104000000},
        '{1'b0, 56'h24022803235959, 56'h24022904000000},
        '{1'b0, 56'h24022904235959, 56'h24030105000000},
        '{1'b0, 56'h99123106235959, 56'h00010107000000},
        '{1'b0, 56'h49013102235959, 56'h49020103000000},
        '{1'b1, 56'h00021C03173B3B, 56'h00021D04000000},
        '{1'b1, 56'h630C1F06173B3B, 56'h00010107000000},
        '{1'b1, 56'h0A050501003B3B, 56'h0A050501010000},
        '{1'b1, 56'h170B1E02173B3B, 56'h170C0103000000}
    };
    localparam logic [3:0] FA [7] = '{4'd0, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pps_tick = 1'b0;
    logic       prd_tick = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       cfg_err;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    rtc_calendar uut (
        .clk(clk), .rst(rst), .pps_tick(pps_tick), .prd_tick(prd_tick),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic second();
        @(negedge clk);
        pps_tick = 1'b1;
        @(negedge clk);
        pps_tick = 1'b0;
    endtask

    task automatic load_cal(input logic [55:0] t);
        for (int i = 0; i < 7; i++) wr(FA[i], t[i*8 +: 8]);
    endtask

    task automatic read_cal(output logic [55:0] t);
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin
            rd(FA[i], b);
            t[i*8 +: 8] = b;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  b;
        logic [55:0] t;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_cal(t);
        check("R1 reset calendar", 64'(t), 64'h00010107000000);
        rd(4'd11, b);  check("R1 reset control", 64'(b), 64'h42);
        rd(4'd1, b);   check("R1 reset spare", 64'(b), 64'h00);
        check("R1 reset err", 64'(cfg_err), 64'h0);
        // R9 update flag flips on each read
        rd(4'd10, b);  check("R1 R9 first status read", 64'(b), 64'hA6);
        rd(4'd10, b);  check("R9 second status read", 64'(b), 64'h26);

        // R3 R4 R5 R6 R7 vector table
        for (int v = 0; v < NV; v++) begin
            wr(4'd11, VECS[v].bin ? 8'h06 : 8'h02);
            load_cal(VECS[v].t0);
            second();
            read_cal(t);
            check($sformatf("R3/R4 R5 R6 R7 vector %0d", v), 64'(t), 64'(VECS[v].t1));
        end

        // R2 storage bytes and readback
        wr(4'd11, 8'h02);
        wr(4'd3, 8'h5A);
        rd(4'd3, b);   check("R2 spare byte", 64'(b), 64'h5A);
        wr(4'd7, 8'h17);
        rd(4'd7, b);   check("R2 mday readback", 64'(b), 64'h17);

        // R8 freeze
        wr(4'd0, 8'h30);
        wr(4'd11, 8'h82);
        second();
        rd(4'd0, b);   check("R8 frozen seconds", 64'(b), 64'h30);
        wr(4'd11, 8'h02);
        second();
        rd(4'd0, b);   check("R8 unfrozen seconds", 64'(b), 64'h31);

        // R13 write beats tick on the same field
        wr(4'd2, 8'h05);
        wr(4'd0, 8'h20);
        @(negedge clk);
        bus_addr = 4'd0; bus_wdata = 8'h45; bus_we = 1'b1; pps_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; pps_tick = 1'b0;
        rd(4'd0, b);   check("R13 write wins", 64'(b), 64'h45);
        rd(4'd2, b);   check("R13 minutes untouched", 64'(b), 64'h05);

        // R9 status write keeps flag
        wr(4'd10, 8'h91);
        rd(4'd10, b);  check("R9 status write", 64'(b), 64'h91);

        // R10 rejected control write
        wr(4'd11, 8'h12);
        check("R10 err set", 64'(cfg_err), 64'h1);
        rd(4'd11, b);  check("R10 control kept", 64'(b), 64'h02);
        wr(4'd11, 8'h4A);
        rd(4'd11, b);  check("R10 accepted write", 64'(b), 64'h4A);
        check("R10 err sticky", 64'(cfg_err), 64'h1);

        // R11 periodic interrupt gating (control now has bit 6 set)
        @(negedge clk); prd_tick = 1'b1;
        @(negedge clk); prd_tick = 1'b0;
        check("R11 irq pulse", 64'(irq), 64'h1);
        @(negedge clk);
        check("R11 irq one cycle", 64'(irq), 64'h0);
        wr(4'd11, 8'h02);
        @(negedge clk); prd_tick = 1'b1;
        @(negedge clk); prd_tick = 1'b0;
        check("R11 irq gated off", 64'(irq), 64'h0);

        // R12 zero registers
        wr(4'd12, 8'hFF);
        rd(4'd12, b);  check("R12 addr 12", 64'(b), 64'h00);
        rd(4'd13, b);  check("R12 addr 13", 64'(b), 64'h00);
        wr(4'd14, 8'hFF);
        rd(4'd14, b);  check("R12 addr 14", 64'(b), 64'h00);
        rd(4'd11, b);  check("R12 control unaffected", 64'(b), 64'h02);

        finish_run();
    end
endmodule